// File: doc/BRIEF.md
# Single-Address Directory Home Controller

This block is the home side of a directory-based coherence scheme for one memory line shared by a configurable number of cache nodes. It keeps the line's memory value, a bit per node recording which nodes hold a copy, a second bit vector of nodes still to be invalidated, and a flag saying that one node has been given the line exclusively. Requests are served strictly one at a time: while a request is open the home sends invalidations, absorbs the acknowledgements (with any written-back data) and finally answers the requester with a shared or an exclusive grant carrying the memory value.

Every node has three one-entry slots at the home boundary. Its request slot is presented as `req_valid`/`req_excl` and is emptied with a `req_pop` pulse. Its home-to-node slot is free when `snd_ready` is high, and the home fills it by raising that node's bit of `snd_valid`. Its acknowledgement slot is presented as `ack_valid`/`ack_data` and is emptied by `ack_pop`. The home performs at most one action per clock, and separate round-robin pointers choose among nodes competing for acceptance, invalidation and acknowledgement handling.

The controller has three states. IDLE: no request open. SHR_REQ: a shared-read request is open. EXC_REQ: an exclusive request is open. Transitions: IDLE to SHR_REQ or EXC_REQ on accepting a request (by its `req_excl` bit); SHR_REQ to IDLE on sending the shared grant; EXC_REQ to IDLE on sending the exclusive grant. Sending an invalidation and taking an acknowledgement keep the state.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset no output is asserted, no node is marked as a holder, the exclusive flag is clear, and memory holds `MEM_INIT`; so the first exclusive request is granted in the cycle after it is accepted, with data `MEM_INIT`.
- R2: A request is accepted only while no request is open; acceptance is shown by a one-cycle `req_pop` pulse for that node, in the cycle its `req_valid` is seen; requests that arrive while a request is open stay unpopped.
- R3: Among several eligible nodes, each of the three pickers (accept, invalidate, acknowledge) chooses the first eligible node at or after its pointer, and its pointer then moves to one past the node chosen, wrapping at N.
- R4: On acceptance the holder vector is copied into the invalidate vector. An invalidation (`snd_cmd` = 1) goes to node j only if j is in that vector, `snd_ready[j]` is high, and the open request is exclusive or is shared while the exclusive flag is set; each node receives it once per request.
- R5: A shared grant (`snd_cmd` = 2) goes to the requester when the open request is shared, the exclusive flag is clear and the requester's `snd_ready` is high; it carries the memory value, marks the requester as a holder and closes the request. A shared read with the flag clear sends no invalidation.
- R6: An exclusive grant (`snd_cmd` = 3) goes to the requester only when the open request is exclusive, no node is marked as a holder, the exclusive flag is clear and the requester's `snd_ready` is high; it carries the memory value, marks the requester and sets the flag.
- R7: An acknowledgement taken while the exclusive flag is set writes its data into memory, clears the flag and clears the sender's holder bit.
- R8: An acknowledgement taken while the exclusive flag is clear clears only the sender's holder bit; memory keeps its value.
- R9: Acknowledgements are taken only while a request is open; in IDLE `ack_pop` stays low.
- R10: At most one action happens per cycle: at most one bit of `snd_valid`, `req_pop` and `ack_pop` together is high, and when an acknowledgement can be taken no invalidation, grant or acceptance happens in that cycle.
- R11: `req_excl` = 1 marks an exclusive request, 0 a shared one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Request slot of each node is occupied |
| req_excl | input | N | Kind of the request in each slot: 1 exclusive, 0 shared |
| req_pop | output | N | Empties the request slot of the accepted node |
| snd_ready | input | N | Home-to-node slot of each node is free |
| snd_valid | output | N | Fills the home-to-node slot of one node |
| snd_cmd | output | 2 | Message kind: 1 invalidate, 2 shared grant, 3 exclusive grant, 0 none |
| snd_data | output | DW | Memory value carried by a grant, zero otherwise |
| ack_valid | input | N | Acknowledgement slot of each node is occupied |
| ack_data | input | N*DW | Data of each node's acknowledgement, node k at bits k*DW upward |
| ack_pop | output | N | Empties the acknowledgement slot of the node taken |

## Verification
A wrong holder or invalidate vector shows up one or two cycles after the next acceptance, as a missing, extra or misdirected invalidation, or as an exclusive grant that comes too early or never. A wrong exclusive flag or memory write shows as invalidations sent for a plain shared read, or as a grant whose data is not the last written-back value; the bench follows each request through to its grant so these surface within a few cycles. Pointer faults show as a different node being served first when several compete.

// File: rtl/home_dir_pkg.sv
package home_dir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHR_REQ = 2'd1,
        ST_EXC_REQ = 2'd2
    } home_state_e;

    typedef enum logic [1:0] {
        SND_NONE = 2'd0,
        SND_INV  = 2'd1,
        SND_GNTS = 2'd2,
        SND_GNTE = 2'd3
    } snd_cmd_e;

    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_ACCEPT  = 3'd1,
        ACT_INV     = 3'd2,
        ACT_ACK     = 3'd3,
        ACT_GRANT_S = 3'd4,
        ACT_GRANT_E = 3'd5
    } home_act_e;

endpackage

// File: rtl/home_rr_arb.sv
module home_rr_arb #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);

    logic [IW-1:0] ptr_q;
    logic [IW:0]   cand;

    always_comb begin
        gnt_idx = '0;
        any     = 1'b0;
        cand    = '0;
        for (int k = N - 1; k >= 0; k--) begin
            cand = {1'b0, ptr_q} + (IW+1)'(k);
            if (cand >= (IW+1)'(N)) begin
                cand = cand - (IW+1)'(N);
            end
            if (req[cand[IW-1:0]]) begin
                gnt_idx = cand[IW-1:0];
                any     = 1'b1;
            end
        end
    end

    always_comb begin
        gnt = '0;
        if (any) begin
            gnt[gnt_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take && any) begin
            if (gnt_idx == IW'(N - 1)) begin
                ptr_q <= '0;
            end else begin
                ptr_q <= gnt_idx + 1'b1;
            end
        end
    end

    AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R3
    AST_ARB_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R3

endmodule

// File: rtl/home_dir_elig.sv
module home_dir_elig
    import home_dir_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  home_state_e   state,
    input  logic          excl_set,
    input  logic [N-1:0]  holders,
    input  logic [N-1:0]  inv_pend,
    input  logic [IW-1:0] cur_node,
    input  logic [N-1:0]  req_valid,
    input  logic [N-1:0]  snd_ready,
    input  logic [N-1:0]  ack_valid,
    output logic [N-1:0]  accept_elig,
    output logic [N-1:0]  inv_elig,
    output logic [N-1:0]  ack_elig,
    output logic          gnt_s_ok,
    output logic          gnt_e_ok
);

    logic busy;
    logic inv_mode;

    always_comb begin
        busy     = (state != ST_IDLE);
        inv_mode = (state == ST_EXC_REQ) || ((state == ST_SHR_REQ) && excl_set);

        accept_elig = busy ? '0 : req_valid;
        ack_elig    = busy ? ack_valid : '0;
        inv_elig    = inv_mode ? (inv_pend & snd_ready) : '0;

        gnt_s_ok = (state == ST_SHR_REQ) && !excl_set && snd_ready[cur_node];
        gnt_e_ok = (state == ST_EXC_REQ) && !excl_set && (holders == '0)
                   && snd_ready[cur_node];
    end

endmodule

// File: rtl/home_dir_store.sv
module home_dir_store
    import home_dir_pkg::*;
#(
    parameter int          N        = 4,
    parameter int          DW       = 8,
    parameter logic [DW-1:0] MEM_INIT = '0,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  home_act_e     act,
    input  logic [IW-1:0] cur_node,
    input  logic [IW-1:0] inv_idx,
    input  logic [IW-1:0] ack_idx,
    input  logic [DW-1:0] ack_word,
    output logic [N-1:0]  holders,
    output logic [N-1:0]  inv_pend,
    output logic          excl_set,
    output logic [DW-1:0] mem_val
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holders  <= '0;
            inv_pend <= '0;
            excl_set <= 1'b0;
            mem_val  <= MEM_INIT;
        end else begin
            unique case (act)
                ACT_ACCEPT: begin
                    inv_pend <= holders;
                end
                ACT_INV: begin
                    inv_pend[inv_idx] <= 1'b0;
                end
                ACT_ACK: begin
                    holders[ack_idx] <= 1'b0;
                    if (excl_set) begin
                        excl_set <= 1'b0;
                        mem_val  <= ack_word;
                    end
                end
                ACT_GRANT_S: begin
                    holders[cur_node] <= 1'b1;
                end
                ACT_GRANT_E: begin
                    holders[cur_node] <= 1'b1;
                    excl_set          <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    AST_ACK_WRITES_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ACK && excl_set) |=> (mem_val == $past(ack_word) && !excl_set)); // R7
    AST_ACK_KEEPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_ACK && !excl_set) |=> $stable(mem_val)); // R8

endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
    import home_dir_pkg::*;
#(
    parameter int            N        = 4,
    parameter int            DW       = 8,
    parameter logic [DW-1:0] MEM_INIT = 8'h5A,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_valid,
    input  logic [N-1:0]    req_excl,
    output logic [N-1:0]    req_pop,
    input  logic [N-1:0]    snd_ready,
    output logic [N-1:0]    snd_valid,
    output logic [1:0]      snd_cmd,
    output logic [DW-1:0]   snd_data,
    input  logic [N-1:0]    ack_valid,
    input  logic [N*DW-1:0] ack_data,
    output logic [N-1:0]    ack_pop
);

    home_state_e   state_q, state_d;
    logic [IW-1:0] cur_q;
    home_act_e     act;

    logic [N-1:0]  holders, inv_pend;
    logic          excl_set;
    logic [DW-1:0] mem_val;

    logic [N-1:0]  accept_elig, inv_elig, ack_elig;
    logic          gnt_s_ok, gnt_e_ok;

    logic [N-1:0]  acc_gnt, inv_gnt, ack_gnt;
    logic [IW-1:0] acc_idx, inv_idx, ack_idx;
    logic          acc_any, inv_any, ack_any;
    logic [DW-1:0] ack_word;

    home_dir_elig #(.N(N)) u_elig (
        .state       (state_q),
        .excl_set    (excl_set),
        .holders     (holders),
        .inv_pend    (inv_pend),
        .cur_node    (cur_q),
        .req_valid   (req_valid),
        .snd_ready   (snd_ready),
        .ack_valid   (ack_valid),
        .accept_elig (accept_elig),
        .inv_elig    (inv_elig),
        .ack_elig    (ack_elig),
        .gnt_s_ok    (gnt_s_ok),
        .gnt_e_ok    (gnt_e_ok)
    );

    home_rr_arb #(.N(N)) u_acc_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (accept_elig),
        .take    (act == ACT_ACCEPT),
        .gnt     (acc_gnt),
        .gnt_idx (acc_idx),
        .any     (acc_any)
    );

    home_rr_arb #(.N(N)) u_inv_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (inv_elig),
        .take    (act == ACT_INV),
        .gnt     (inv_gnt),
        .gnt_idx (inv_idx),
        .any     (inv_any)
    );

    home_rr_arb #(.N(N)) u_ack_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (ack_elig),
        .take    (act == ACT_ACK),
        .gnt     (ack_gnt),
        .gnt_idx (ack_idx),
        .any     (ack_any)
    );

    always_comb begin
        ack_word = ack_data[ack_idx*DW +: DW];
    end

    home_dir_store #(.N(N), .DW(DW), .MEM_INIT(MEM_INIT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .cur_node (cur_q),
        .inv_idx  (inv_idx),
        .ack_idx  (ack_idx),
        .ack_word (ack_word),
        .holders  (holders),
        .inv_pend (inv_pend),
        .excl_set (excl_set),
        .mem_val  (mem_val)
    );

    // Action choice and next state: acknowledgement, then invalidation,
    // then grant; acceptance only while idle.
    always_comb begin
        act     = ACT_NONE;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_any) begin
                    act     = ACT_ACCEPT;
                    state_d = req_excl[acc_idx] ? ST_EXC_REQ : ST_SHR_REQ;
                end
            end
            ST_SHR_REQ: begin
                if (ack_any) begin
                    act = ACT_ACK;
                end else if (inv_any) begin
                    act = ACT_INV;
                end else if (gnt_s_ok) begin
                    act     = ACT_GRANT_S;
                    state_d = ST_IDLE;
                end
            end
            ST_EXC_REQ: begin
                if (ack_any) begin
                    act = ACT_ACK;
                end else if (inv_any) begin
                    act = ACT_INV;
                end else if (gnt_e_ok) begin
                    act     = ACT_GRANT_E;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (act == ACT_ACCEPT) begin
                cur_q <= acc_idx;
            end
        end
    end

    always_comb begin
        req_pop   = '0;
        ack_pop   = '0;
        snd_valid = '0;
        snd_cmd   = SND_NONE;
        snd_data  = '0;
        unique case (act)
            ACT_ACCEPT: req_pop = acc_gnt;
            ACT_ACK:    ack_pop = ack_gnt;
            ACT_INV: begin
                snd_valid = inv_gnt;
                snd_cmd   = SND_INV;
            end
            ACT_GRANT_S: begin
                snd_valid[cur_q] = 1'b1;
                snd_cmd          = SND_GNTS;
                snd_data         = mem_val;
            end
            ACT_GRANT_E: begin
                snd_valid[cur_q] = 1'b1;
                snd_cmd          = SND_GNTE;
                snd_data         = mem_val;
            end
            default: begin
            end
        endcase
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({snd_valid, req_pop, ack_pop}) <= 1); // R10
    AST_POP_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pop != '0) |-> (state_q == ST_IDLE && (req_pop & ~req_valid) == '0)); // R2
    AST_SEND_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid & ~snd_ready) == '0); // R4
    AST_ACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pop != '0) |-> (state_q != ST_IDLE)); // R9
    AST_GNTE_SETS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid != '0 && snd_cmd == SND_GNTE) |=> (excl_set && state_q == ST_IDLE)); // R6
    AST_GNTE_NO_HOLDERS: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid != '0 && snd_cmd == SND_GNTE) |-> (holders == '0 && !excl_set)); // R6
    AST_GNTS_NOT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid != '0 && snd_cmd == SND_GNTS) |-> !excl_set); // R5

endmodule

// File: tb/home_dir_ctrl_tb.sv
`timescale 1ns/100ps
module home_dir_ctrl_tb;

    localparam int N  = 4;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N-1:0]    req_excl = '0;
    logic [N-1:0]    req_pop;
    logic [N-1:0]    snd_ready = '1;
    logic [N-1:0]    snd_valid;
    logic [1:0]      snd_cmd;
    logic [DW-1:0]   snd_data;
    logic [N-1:0]    ack_valid = '0;
    logic [N*DW-1:0] ack_data = '0;
    logic [N-1:0]    ack_pop;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    home_dir_ctrl #(.N(N), .DW(DW), .MEM_INIT(8'h5A)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_excl  (req_excl),
        .req_pop   (req_pop),
        .snd_ready (snd_ready),
        .snd_valid (snd_valid),
        .snd_cmd   (snd_cmd),
        .snd_data  (snd_data),
        .ack_valid (ack_valid),
        .ack_data  (ack_data),
        .ack_pop   (ack_pop)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic chk_snd(input string tag, input logic [N-1:0] v,
                           input logic [1:0] c, input logic [DW-1:0] d);
        chk({tag, " snd_valid"}, 32'(snd_valid), 32'(v));
        chk({tag, " snd_cmd"},   32'(snd_cmd),   32'(c));
        chk({tag, " snd_data"},  32'(snd_data),  32'(d));
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset snd_valid", 32'(snd_valid), 0);
        chk("R1 reset req_pop",   32'(req_pop),   0);
        chk("R1 reset ack_pop",   32'(ack_pop),   0);

        // Exclusive request from node 0 on an empty directory
        nxt(); req_valid = 4'b0001; req_excl = 4'b0001; #1;
        chk("R2 R11 accept node0", 32'(req_pop), 32'h1);
        nxt(); req_valid = '0; #1;
        chk_snd("R1 R6 GntE node0 initial data", 4'b0001, 2'd3, 8'h5A);

        // Shared read while node 0 holds the line exclusively
        nxt(); req_valid = 4'b0010; req_excl = '0; #1;
        chk("R2 accept node1", 32'(req_pop), 32'h2);
        nxt(); req_valid = '0; #1;
        chk_snd("R4 Inv to exclusive owner", 4'b0001, 2'd1, 8'h00);
        nxt(); #1;
        chk("R4 no send while waiting ack", 32'(snd_valid), 0);
        nxt(); ack_valid = 4'b0001; ack_data[0*DW +: DW] = 8'hC3; #1;
        chk("R7 ack from owner taken", 32'(ack_pop), 32'h1);
        nxt(); ack_valid = '0; #1;
        chk_snd("R5 R7 GntS carries written-back data", 4'b0010, 2'd2, 8'hC3);

        // Stray acknowledgement while idle
        nxt(); ack_valid = 4'b0100; ack_data[2*DW +: DW] = 8'h11; #1;
        chk("R9 no ack taken while idle", 32'(ack_pop), 0);
        chk("R9 nothing sent while idle", 32'(snd_valid), 0);

        // Plain shared read: no invalidation
        nxt(); ack_valid = '0; req_valid = 4'b0100; #1;
        chk("R2 accept node2", 32'(req_pop), 32'h4);
        nxt(); req_valid = '0; #1;
        chk_snd("R5 GntS without Inv", 4'b0100, 2'd2, 8'hC3);

        // Exclusive request with two sharers, slot back-pressure
        nxt(); req_valid = 4'b1000; req_excl = 4'b1000; #1;
        chk("R2 accept node3", 32'(req_pop), 32'h8);
        nxt(); req_valid = '0; req_excl = '0; #1;
        chk_snd("R3 R4 first Inv to node1", 4'b0010, 2'd1, 8'h00);
        nxt(); snd_ready = 4'b1011; #1;
        chk("R4 Inv held by busy slot", 32'(snd_valid), 0);
        nxt(); snd_ready = '1; #1;
        chk_snd("R4 Inv to node2 after slot frees", 4'b0100, 2'd1, 8'h00);
        nxt(); ack_valid = 4'b0110; ack_data[1*DW +: DW] = 8'h99; ack_data[2*DW +: DW] = 8'hAA; #1;
        chk("R3 ack node1 first", 32'(ack_pop), 32'h2);
        chk("R10 no send with ack", 32'(snd_valid), 0);
        nxt(); ack_valid = 4'b0100; #1;
        chk("R3 ack node2 second", 32'(ack_pop), 32'h4);
        nxt(); ack_valid = '0; snd_ready = 4'b0111; req_valid = 4'b0111; #1;
        chk("R6 GntE held by busy slot", 32'(snd_valid), 0);
        chk("R2 no accept while busy", 32'(req_pop), 0);
        nxt(); snd_ready = '1; #1;
        chk_snd("R6 R8 GntE data unchanged by clean acks", 4'b1000, 2'd3, 8'hC3);
        chk("R10 no accept with grant", 32'(req_pop), 0);

        // Three competing shared reads against an exclusive owner
        nxt(); #1;
        chk("R3 accept node0 first", 32'(req_pop), 32'h1);
        nxt(); req_valid = 4'b0110; #1;
        chk_snd("R4 Inv to node3", 4'b1000, 2'd1, 8'h00);
        nxt(); ack_valid = 4'b1000; ack_data[3*DW +: DW] = 8'h77; #1;
        chk("R7 ack from node3", 32'(ack_pop), 32'h8);
        nxt(); ack_valid = '0; #1;
        chk_snd("R5 R7 GntS node0 data", 4'b0001, 2'd2, 8'h77);
        nxt(); #1;
        chk("R3 accept node1 next", 32'(req_pop), 32'h2);
        nxt(); req_valid = 4'b0100; #1;
        chk_snd("R5 GntS node1", 4'b0010, 2'd2, 8'h77);
        nxt(); #1;
        chk("R3 accept node2 last", 32'(req_pop), 32'h4);
        nxt(); req_valid = '0; #1;
        chk_snd("R5 GntS node2", 4'b0100, 2'd2, 8'h77);

        // Upgrade by a sharer: every holder, itself included, is invalidated
        nxt(); req_valid = 4'b0010; req_excl = 4'b0010; #1;
        chk("R2 accept upgrade node1", 32'(req_pop), 32'h2);
        nxt(); req_valid = '0; req_excl = '0; #1;
        chk_snd("R3 R4 Inv node0", 4'b0001, 2'd1, 8'h00);
        nxt(); #1;
        chk_snd("R4 Inv node1", 4'b0010, 2'd1, 8'h00);
        nxt(); #1;
        chk_snd("R4 Inv node2", 4'b0100, 2'd1, 8'h00);
        nxt(); ack_valid = 4'b0111;
        ack_data[0*DW +: DW] = 8'h01; ack_data[1*DW +: DW] = 8'h02; ack_data[2*DW +: DW] = 8'h03; #1;
        chk("R3 ack node0", 32'(ack_pop), 32'h1);
        nxt(); ack_valid = 4'b0110; #1;
        chk("R3 ack node1", 32'(ack_pop), 32'h2);
        nxt(); ack_valid = 4'b0100; #1;
        chk("R3 ack node2", 32'(ack_pop), 32'h4);
        nxt(); ack_valid = '0; #1;
        chk_snd("R6 R8 GntE upgrade keeps memory", 4'b0010, 2'd3, 8'h77);
        nxt(); #1;
        chk("R10 idle afterwards", 32'(snd_valid | req_pop | ack_pop), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule